// File: doc/BRIEF.md
# Scaler Step Value Generator

This block computes the fixed-point resampling step that a video scaler needs for one axis, together with the per-plane values derived from it. A request carries a source size, a destination size, a reduction mode and an axis select (horizontal or vertical).

The master step is the pre-reduced source size times 2^21, divided by the destination size and rounded up. The pre-reduction is none, half or quarter, depending on the mode.

A restoring divider produces the quotient one bit per clock. A rounding cycle follows it, and then a cycle that registers all derived values. Every output then stays as it is until the next accepted request.

A request is taken when `start` is high while `ready` is high. A request with a zero destination size is refused at once, as is a request with the undefined mode code. A refused request raises `err` and leaves `ready` high.

Top module: `scl_step_gen`

## Requirements
- R1: After reset, `ready` is 1 and both `out_valid` and `err` are 0.
- R2: With mode code 00 (enlarge), `master_step` equals ceil(src_size * 2^21 / dst_size), and `div_code` is 00.
- R3: With mode code 01 (half), the source is first floor-divided by 2 before the step is computed, and `div_code` is 01.
- R4: With mode code 10 (quarter), the source is first floor-divided by 4 before the step is computed, and `div_code` is 10.
- R5: Rounding follows the remainder. A non-zero remainder raises the quotient by one, and an exact division leaves it unchanged.
- R6: When `vert` is 0:
  - `luma_step` and `chroma_step` both equal master>>2.
  - `luma_comp` and `chroma_comp` both equal master>>1.
  - `chroma_aux` is 0.
- R7: When `vert` is 1, `luma_step` equals master>>2, and `luma_comp` equals `luma_step` + 0x514.
- R8: When `vert` is 1, `chroma_step` equals master>>2 with mode 00 and master>>3 with modes 01 and 10. `chroma_comp` equals `chroma_step` + 0x514.
- R9: When `vert` is 1, `chroma_aux` equals master>>1 with mode 00 and master itself with modes 01 and 10.
- R10: A request whose `dst_size` is 0 or whose mode code is 11 sets `err` to 1 and `out_valid` to 0 on the next cycle. In that case `ready` stays 1 and no computation starts.
- R11: Timing of an accepted request:
  - `ready` and `out_valid` fall on the next cycle.
  - `ready` stays low for exactly SRC_W+FRAC+2 cycles (39 with the defaults), after which `ready` and `out_valid` rise together.
  - `start` is ignored while `ready` is low.
  - Results hold until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken while ready is high |
| vert | input | 1 | 0 = horizontal axis, 1 = vertical axis |
| mode | input | 2 | 00 enlarge, 01 half, 10 quarter, 11 invalid |
| src_size | input | SRC_W | Source size in pixels or lines |
| dst_size | input | SRC_W | Destination size in pixels or lines |
| ready | output | 1 | Idle and able to take a request |
| out_valid | output | 1 | Held outputs belong to the last accepted request |
| err | output | 1 | Last request was refused |
| div_code | output | 2 | Output size divider code |
| master_step | output | SRC_W+FRAC | Rounded-up master step |
| luma_step | output | SRC_W+FRAC | Luma step value |
| chroma_step | output | SRC_W+FRAC | Chroma step value |
| luma_comp | output | SRC_W+FRAC | Luma companion value |
| chroma_comp | output | SRC_W+FRAC | Chroma companion value |
| chroma_aux | output | SRC_W+FRAC | Vertical chroma auxiliary value |

## Verification
The bench drives requests whose quotients are both exact and inexact. A design that always rounds up, or that never does, is off by one in `master_step` on one of the two kinds.

Odd source sizes in the half and quarter modes separate floor pre-division from rounded pre-division. Vertical requests in every mode catch a chroma shift or auxiliary value taken from the wrong mode.

Zero destinations, mode 11, `start` pulses during a busy window and the largest source over a destination of 1 probe the refusal path, the exact ready timing and the width of the quotient.

// File: rtl/scl_pkg.sv
package scl_pkg;
  typedef enum logic [1:0] {
    SCL_ENLARGE = 2'b00,
    SCL_HALF    = 2'b01,
    SCL_QUARTER = 2'b10,
    SCL_BADMODE = 2'b11
  } scl_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_DIV    = 2'b01,
    ST_DERIVE = 2'b10
  } scl_state_e;

  localparam int unsigned SCL_COMP_OFS = 32'h0000_0514;
endpackage

// File: rtl/scl_restoring_div.sv
module scl_restoring_div #(
  parameter int NW = 37,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic          done,
  output logic [NW-1:0] quot,
  output logic          rem_nz
);
  localparam int CW = $clog2(NW + 1);

  logic [DW-1:0] rem_q;
  logic [NW-1:0] shf_q;
  logic [DW-1:0] den_q;
  logic [CW-1:0] cnt_q;
  logic [DW:0]   trial;
  logic [DW:0]   diff;
  logic          fits;

  always_comb begin
    trial = {rem_q, shf_q[NW-1]};
    fits  = (trial >= {1'b0, den_q});
    diff  = trial - {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      rem_q <= '0;
      shf_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      quot  <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        rem_q <= '0;
        shf_q <= num;
        den_q <= den;
        quot  <= '0;
        cnt_q <= CW'(NW);
        busy  <= 1'b1;
      end else if (busy) begin
        rem_q <= fits ? diff[DW-1:0] : trial[DW-1:0];
        shf_q <= {shf_q[NW-2:0], 1'b0};
        quot  <= {quot[NW-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign rem_nz = |rem_q;

  // R5: the partial remainder never reaches the divisor
  p_rem_below_den_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (rem_q < den_q));

  // R11: a load starts a busy period
  p_load_busy_r11: assert property (@(posedge clk) disable iff (rst)
    load |=> busy);
endmodule

// File: rtl/scl_derive.sv
module scl_derive
  import scl_pkg::*;
#(
  parameter int MW = 37
) (
  input  logic [MW-1:0] master,
  input  logic          vert,
  input  logic          reduce,
  output logic [MW-1:0] luma_step,
  output logic [MW-1:0] chroma_step,
  output logic [MW-1:0] luma_comp,
  output logic [MW-1:0] chroma_comp,
  output logic [MW-1:0] chroma_aux
);
  localparam logic [MW-1:0] OFS = MW'(SCL_COMP_OFS);

  logic [MW-1:0] quarter_v;
  logic [MW-1:0] half_v;
  logic [MW-1:0] eighth_v;

  always_comb begin
    quarter_v = master >> 2;
    half_v    = master >> 1;
    eighth_v  = master >> 3;
    luma_step = quarter_v;
    if (vert) begin
      chroma_step = reduce ? eighth_v : quarter_v;
      luma_comp   = quarter_v + OFS;
      chroma_comp = chroma_step + OFS;
      chroma_aux  = reduce ? master : half_v;
    end else begin
      chroma_step = quarter_v;
      luma_comp   = half_v;
      chroma_comp = half_v;
      chroma_aux  = '0;
    end
  end
endmodule

// File: rtl/scl_step_gen.sv
module scl_step_gen
  import scl_pkg::*;
#(
  parameter int SRC_W = 16,
  parameter int FRAC  = 21
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  vert,
  input  logic [1:0]            mode,
  input  logic [SRC_W-1:0]      src_size,
  input  logic [SRC_W-1:0]      dst_size,
  output logic                  ready,
  output logic                  out_valid,
  output logic                  err,
  output logic [1:0]            div_code,
  output logic [SRC_W+FRAC-1:0] master_step,
  output logic [SRC_W+FRAC-1:0] luma_step,
  output logic [SRC_W+FRAC-1:0] chroma_step,
  output logic [SRC_W+FRAC-1:0] luma_comp,
  output logic [SRC_W+FRAC-1:0] chroma_comp,
  output logic [SRC_W+FRAC-1:0] chroma_aux
);
  localparam int MW = SRC_W + FRAC;

  scl_state_e      state_q;
  scl_mode_e       mode_in;
  scl_mode_e       mode_q;
  logic            vert_q;
  logic            bad_req;
  logic            accept;
  logic            reject;
  logic [SRC_W-1:0] src_pre;
  logic [MW-1:0]   numer;
  logic            div_busy;
  logic            div_done;
  logic [MW-1:0]   div_quot;
  logic            div_rem_nz;
  logic [MW-1:0]   master_q;
  logic [MW-1:0]   d_luma;
  logic [MW-1:0]   d_chroma;
  logic [MW-1:0]   d_lcomp;
  logic [MW-1:0]   d_ccomp;
  logic [MW-1:0]   d_aux;

  always_comb begin
    mode_in = scl_mode_e'(mode);
    bad_req = (dst_size == '0) || (mode_in == SCL_BADMODE);
    accept  = start && ready && !bad_req;
    reject  = start && ready && bad_req;
    case (mode_in)
      SCL_HALF:    src_pre = src_size >> 1;
      SCL_QUARTER: src_pre = src_size >> 2;
      default:     src_pre = src_size;
    endcase
    numer = {src_pre, {FRAC{1'b0}}};
  end

  scl_restoring_div #(.NW(MW), .DW(SRC_W)) u_div (
    .clk    (clk),
    .rst    (rst),
    .load   (accept),
    .num    (numer),
    .den    (dst_size),
    .busy   (div_busy),
    .done   (div_done),
    .quot   (div_quot),
    .rem_nz (div_rem_nz)
  );

  scl_derive #(.MW(MW)) u_derive (
    .master      (master_q),
    .vert        (vert_q),
    .reduce      (mode_q != SCL_ENLARGE),
    .luma_step   (d_luma),
    .chroma_step (d_chroma),
    .luma_comp   (d_lcomp),
    .chroma_comp (d_ccomp),
    .chroma_aux  (d_aux)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      ready       <= 1'b1;
      out_valid   <= 1'b0;
      err         <= 1'b0;
      mode_q      <= SCL_ENLARGE;
      vert_q      <= 1'b0;
      master_q    <= '0;
      div_code    <= 2'b00;
      master_step <= '0;
      luma_step   <= '0;
      chroma_step <= '0;
      luma_comp   <= '0;
      chroma_comp <= '0;
      chroma_aux  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            ready     <= 1'b0;
            out_valid <= 1'b0;
            err       <= 1'b0;
            mode_q    <= mode_in;
            vert_q    <= vert;
            state_q   <= ST_DIV;
          end else if (reject) begin
            err       <= 1'b1;
            out_valid <= 1'b0;
          end
        end
        ST_DIV: begin
          if (div_done) begin
            master_q <= div_quot + MW'(div_rem_nz);
            state_q  <= ST_DERIVE;
          end
        end
        ST_DERIVE: begin
          master_step <= master_q;
          luma_step   <= d_luma;
          chroma_step <= d_chroma;
          luma_comp   <= d_lcomp;
          chroma_comp <= d_ccomp;
          chroma_aux  <= d_aux;
          div_code    <= mode_q;
          out_valid   <= 1'b1;
          ready       <= 1'b1;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10: a zero destination is refused without leaving the idle state
  p_reject_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (start && ready && dst_size == '0) |=> (err && ready && !out_valid));

  // R11: ready stays low while the divider is working
  p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (rst)
    div_busy |-> !ready);

  // R11: results appear together with ready
  p_valid_with_ready_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> ready);

  // R4: a held result never carries the unused divider code
  p_code_legal_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (div_code != 2'b11));

  // R7: the vertical luma companion sits at a fixed distance from its step
  p_vcomp_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && vert_q) |-> ((luma_comp - luma_step) == MW'(SCL_COMP_OFS)));
endmodule

// File: tb/scl_step_gen_tb.sv
module scl_step_gen_tb;
  localparam int SRC_W = 16;
  localparam int FRAC  = 21;
  localparam int MW    = SRC_W + FRAC;
  localparam int LAT   = MW + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic vert = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [SRC_W-1:0] src_size = '0;
  logic [SRC_W-1:0] dst_size = '0;
  logic ready, out_valid, err;
  logic [1:0] div_code;
  logic [MW-1:0] master_step, luma_step, chroma_step, luma_comp, chroma_comp, chroma_aux;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  scl_step_gen #(.SRC_W(SRC_W), .FRAC(FRAC)) u_dut (
    .clk(clk), .rst(rst), .start(start), .vert(vert), .mode(mode),
    .src_size(src_size), .dst_size(dst_size), .ready(ready),
    .out_valid(out_valid), .err(err), .div_code(div_code),
    .master_step(master_step), .luma_step(luma_step),
    .chroma_step(chroma_step), .luma_comp(luma_comp),
    .chroma_comp(chroma_comp), .chroma_aux(chroma_aux)
  );

  // behavioural reference state
  bit     e_ready = 1'b1, e_valid = 1'b0, e_err = 1'b0;
  int     e_cnt = 0;
  longint e_m, e_l, e_c, e_lc, e_cc, e_aux, e_code;
  longint p_m, p_l, p_c, p_lc, p_cc, p_aux, p_code;
  bit     e_vert;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      e_ready = 1'b1; e_valid = 1'b0; e_err = 1'b0; e_cnt = 0;
    end else if (e_cnt > 0) begin
      e_cnt--;
      if (e_cnt == 0) begin
        e_ready = 1'b1; e_valid = 1'b1;
        e_m = p_m; e_l = p_l; e_c = p_c; e_lc = p_lc; e_cc = p_cc;
        e_aux = p_aux; e_code = p_code;
      end
    end else if (start && e_ready) begin
      if (dst_size == 0 || mode == 2'b11) begin
        e_err = 1'b1; e_valid = 1'b0;
      end else begin
        longint s, n, q;
        s = longint'(src_size) / (longint'(1) << mode);
        n = s * (longint'(1) << FRAC);
        q = n / longint'(dst_size);
        if (n % longint'(dst_size) != 0) q++;
        p_m = q; p_code = mode; e_vert = vert;
        p_l = q / 4;
        if (!vert) begin
          p_c = q / 4; p_lc = q / 2; p_cc = q / 2; p_aux = 0;
        end else begin
          p_c = (mode == 2'b00) ? q / 4 : q / 8;
          p_lc = p_l + 1300;
          p_cc = p_c + 1300;
          p_aux = (mode == 2'b00) ? q / 2 : q;
        end
        e_cnt = LAT; e_ready = 1'b0; e_valid = 1'b0; e_err = 1'b0;
      end
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R11 ready", ready, e_ready);
      chk("R11 out_valid", out_valid, e_valid);
      chk("R10 err", err, e_err);
      if (e_valid) begin
        case (e_code)
          0: chk("R2 R5 master", master_step, e_m);
          1: chk("R3 R5 master", master_step, e_m);
          default: chk("R4 R5 master", master_step, e_m);
        endcase
        chk("R2 R3 R4 div_code", div_code, e_code);
        if (!e_vert) begin
          chk("R6 luma_step", luma_step, e_l);
          chk("R6 chroma_step", chroma_step, e_c);
          chk("R6 luma_comp", luma_comp, e_lc);
          chk("R6 chroma_comp", chroma_comp, e_cc);
          chk("R6 chroma_aux", chroma_aux, e_aux);
        end else begin
          chk("R7 luma_step", luma_step, e_l);
          chk("R7 luma_comp", luma_comp, e_lc);
          chk("R8 chroma_step", chroma_step, e_c);
          chk("R8 chroma_comp", chroma_comp, e_cc);
          chk("R9 chroma_aux", chroma_aux, e_aux);
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic req(input bit v, input logic [1:0] m, input int s, input int d);
    @(negedge clk);
    vert = v; mode = m; src_size = SRC_W'(s); dst_size = SRC_W'(d); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!e_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready", ready, 1);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 err", err, 0);
    // horizontal, every mode, exact and inexact quotients
    req(1'b0, 2'b00, 720, 1440);
    req(1'b0, 2'b00, 100, 300);
    req(1'b0, 2'b01, 721, 360);
    req(1'b0, 2'b10, 723, 180);
    req(1'b0, 2'b01, 1920, 1000);
    // vertical, every mode
    req(1'b1, 2'b00, 480, 576);
    req(1'b1, 2'b01, 577, 288);
    req(1'b1, 2'b10, 1080, 270);
    req(1'b1, 2'b10, 7, 3);
    // refusals hold no result
    req(1'b0, 2'b00, 640, 0);
    req(1'b1, 2'b11, 640, 480);
    // widest quotient
    req(1'b0, 2'b00, 65535, 1);
    req(1'b1, 2'b01, 65535, 65535);
    // start pulses during busy window are ignored (R11)
    @(negedge clk);
    vert = 1'b0; mode = 2'b00; src_size = 16'd300; dst_size = 16'd7; start = 1'b1;
    @(negedge clk);
    src_size = 16'd9; dst_size = 16'd0; mode = 2'b01;
    repeat (5) @(negedge clk);
    start = 1'b0;
    while (!e_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule